// File: doc/BRIEF.md
# Latchable Parity Transceiver with Dual Checker

This block moves an 8-bit data word and its parity bit between two buses, called side A and side B. Each side has an input store that is either transparent or holding, under its own capture enable. Each direction has its own active-low drive enable. The word that reaches the far bus carries one of two parity bits. In generate mode the block recomputes the parity bit from the data. In feed-through mode it copies the parity bit it received. A sense select picks odd or even parity for both sides.

Each side has its own checker. The checker recomputes parity over the word seen at that side, which is either the live pins or the held word, and flags a mismatch on an active-low error output. When a side is being driven and its store is transparent, the store sees the driven word, so that side's checker also checks the outgoing word. Tri-state pins appear as separate input, output and output-enable ports. The stores are clock-enabled registers with a transparent bypass.

Top module: `par_xcvr`

## Requirements
- R1: With `drv_ab_n` and `drv_ba_n` both 1, `a_oe`, `b_oe` and `dir_conflict` are all 0.
- R2: `drv_ab_n`=0 sets `b_oe`=1, and `b_data_o` carries side A's source data. `drv_ba_n`=0 with `drv_ab_n`=1 sets `a_oe`=1, and `a_data_o` carries side B's source data.
- R3: When both drive enables are 0, `dir_conflict`=1, `b_oe`=1 and `a_oe`=0, so the A-to-B direction wins.
- R4: With a side's capture enable at 1, the side's source word is its live pins {par,data}, and the register loads the word at that side on each rising edge.
- R5: With a side's capture enable at 0, the side uses its held word, and changes on its input pins have no effect on the outputs.
- R6: With `fwd_mode`=0, the driven parity bit equals XOR of the 8 source data bits when `odd_sel`=0 (even). It equals the inverted XOR when `odd_sel`=1 (odd).
- R7: With `fwd_mode`=1, the driven parity bit equals the source parity bit unchanged.
- R8: A side's error output is 0 exactly when the ones-count of its checked 9-bit word {par,data} modulo 2 differs from `odd_sel`. This holds in both modes.
- R9: A side that is being driven with its capture enable at 1 checks, and captures, the driven word instead of its input pins.
- R10: A synchronous reset (`rst_n`=0 at a rising edge) clears both held words to all zeros.
- R11: A side that is not driven outputs zeros on its data and parity outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the capture registers |
| rst_n | input | 1 | Synchronous active-low reset |
| drv_ab_n | input | 1 | Active-low enable, drive side B from side A |
| drv_ba_n | input | 1 | Active-low enable, drive side A from side B |
| fwd_mode | input | 1 | 1 copies the received parity bit, 0 generates a fresh one |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even |
| cap_a | input | 1 | Side A store transparent (1) or holding (0) |
| cap_b | input | 1 | Side B store transparent (1) or holding (0) |
| a_data_i | input | 8 | Side A data pins, input view |
| a_par_i | input | 1 | Side A parity pin, input view |
| a_data_o | output | 8 | Side A data driven value |
| a_par_o | output | 1 | Side A parity driven value |
| a_oe | output | 1 | Side A pins driven |
| b_data_i | input | 8 | Side B data pins, input view |
| b_par_i | input | 1 | Side B parity pin, input view |
| b_data_o | output | 8 | Side B data driven value |
| b_par_o | output | 1 | Side B parity driven value |
| b_oe | output | 1 | Side B pins driven |
| a_err_n | output | 1 | Side A parity mismatch, active low |
| b_err_n | output | 1 | Side B parity mismatch, active low |
| dir_conflict | output | 1 | Both drive enables asserted together |

## Verification
The bench sweeps all 64 settings of drive enables, mode, sense and capture enables. For each setting it applies correct words, words with a bad parity bit and words with a flipped data bit, with the parity bit correct or bad on each side independently. A design that checked the input pins of a driven side, instead of the driven word, would miss the parity it had just generated and raise wrong errors on the destination side. A design whose stores leaked live pins while holding would fail on a later step, where the held word differs from the pins. Other faults the sweep exposes are a swapped parity sense, a parity bit regenerated in feed-through mode, and both sides driven in a conflict.

// File: rtl/ptx_pkg.sv
// Package: shared side indices for the parity transceiver.
// Assumes exactly two sides; index 0 is side A, index 1 is side B.
package ptx_pkg;
    localparam int NUM_SIDES = 2;
    localparam int SIDE_A    = 0;
    localparam int SIDE_B    = 1;
endpackage

// File: rtl/ptx_parity_unit.sv
// Module: ptx_parity_unit
// Computes the parity bit that makes {par,data} have the selected sense.
// Assumes odd_sel = 1 means odd total ones, 0 means even.
module ptx_parity_unit #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              odd_sel,
    output logic              gen_par
);
    // Reduction XOR then sense flip.
    always_comb begin
        gen_par = (^data) ^ odd_sel;
    end
endmodule

// File: rtl/ptx_side_latch.sv
// Module: ptx_side_latch
// Per-side input store: a clock-enabled register with a transparent bypass.
// While le is high it passes the live word and loads it on each rising edge.
// While le is low it presents the held word. The live word is the driven
// word when this side is being driven (loopback), else the input pins.
module ptx_side_latch #(
    parameter int DATA_W = 8,
    localparam int WORD_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le,
    input  logic [WORD_W-1:0] pin_word,
    input  logic [WORD_W-1:0] drv_word,
    input  logic              drv_en,
    output logic [WORD_W-1:0] src_word,
    output logic [WORD_W-1:0] chk_word
);
    logic [WORD_W-1:0] held;
    logic [WORD_W-1:0] live;

    // Word present on this side's bus: driven value or external input.
    always_comb begin
        live = drv_en ? drv_word : pin_word;
    end

    // Capture register: cleared by reset, loads while transparent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (le) begin
            held <= live;
        end
    end

    // Source view uses the input pins only (used when this side sends).
    always_comb begin
        src_word = le ? pin_word : held;
    end

    // Check view follows whatever this side's bus carries.
    always_comb begin
        chk_word = le ? live : held;
    end

    // Holding store must not change while the enable is low.
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !le |=> $stable(held));

    // Transparent store must capture the bus word seen at the edge.
    assert_load_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> (held == $past(live)));
endmodule

// File: rtl/ptx_route.sv
// Module: ptx_route
// Forms the word driven toward the far side: data copied, parity either
// regenerated (fwd_mode = 0) or taken from the source word (fwd_mode = 1).
module ptx_route #(
    parameter int DATA_W = 8,
    localparam int WORD_W = DATA_W + 1
) (
    input  logic [WORD_W-1:0] src_word,
    input  logic              fwd_mode,
    input  logic              odd_sel,
    output logic [WORD_W-1:0] out_word
);
    logic fresh_par;

    ptx_parity_unit #(.DATA_W(DATA_W)) u_gen (
        .data    (src_word[DATA_W-1:0]),
        .odd_sel (odd_sel),
        .gen_par (fresh_par)
    );

    // Select outgoing parity by mode and attach the data.
    always_comb begin
        out_word = {(fwd_mode ? src_word[DATA_W] : fresh_par), src_word[DATA_W-1:0]};
    end
endmodule

// File: rtl/ptx_checker.sv
// Module: ptx_checker
// Compares regenerated parity of a 9-bit word with its own parity bit.
// err_n is low on mismatch; it works the same in both modes.
module ptx_checker #(
    parameter int DATA_W = 8,
    localparam int WORD_W = DATA_W + 1
) (
    input  logic [WORD_W-1:0] chk_word,
    input  logic              odd_sel,
    output logic              err_n
);
    logic expect_par;

    ptx_parity_unit #(.DATA_W(DATA_W)) u_gen (
        .data    (chk_word[DATA_W-1:0]),
        .odd_sel (odd_sel),
        .gen_par (expect_par)
    );

    // Flag a mismatch between carried and expected parity.
    always_comb begin
        err_n = (expect_par == chk_word[DATA_W]);
    end
endmodule

// File: rtl/par_xcvr.sv
// Module: par_xcvr (top)
// Bidirectional data+parity transceiver with a store and checker per side.
// Assumes external tri-state resolution: *_oe marks when the *_o values own
// the bus. When both drive enables are asserted, A-to-B wins and a
// conflict is flagged.
module par_xcvr #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drv_ab_n,
    input  logic              drv_ba_n,
    input  logic              fwd_mode,
    input  logic              odd_sel,
    input  logic              cap_a,
    input  logic              cap_b,
    input  logic [DATA_W-1:0] a_data_i,
    input  logic              a_par_i,
    output logic [DATA_W-1:0] a_data_o,
    output logic              a_par_o,
    output logic              a_oe,
    input  logic [DATA_W-1:0] b_data_i,
    input  logic              b_par_i,
    output logic [DATA_W-1:0] b_data_o,
    output logic              b_par_o,
    output logic              b_oe,
    output logic              a_err_n,
    output logic              b_err_n,
    output logic              dir_conflict
);
    import ptx_pkg::*;

    localparam int WORD_W = DATA_W + 1;

    logic [NUM_SIDES-1:0][WORD_W-1:0] pin_w;
    logic [NUM_SIDES-1:0][WORD_W-1:0] src_w;
    logic [NUM_SIDES-1:0][WORD_W-1:0] chk_w;
    logic [NUM_SIDES-1:0][WORD_W-1:0] drv_w;
    logic [NUM_SIDES-1:0]             drv_en;
    logic [NUM_SIDES-1:0]             le_v;
    logic [NUM_SIDES-1:0]             err_v;

    // Direction arbitration: A-to-B has priority over B-to-A.
    always_comb begin
        dir_conflict   = !drv_ab_n && !drv_ba_n;
        drv_en[SIDE_B] = !drv_ab_n;
        drv_en[SIDE_A] = !drv_ba_n && drv_ab_n;
    end

    // Gather per-side pin words and capture enables.
    always_comb begin
        pin_w[SIDE_A] = {a_par_i, a_data_i};
        pin_w[SIDE_B] = {b_par_i, b_data_i};
        le_v[SIDE_A]  = cap_a;
        le_v[SIDE_B]  = cap_b;
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam int PEER = NUM_SIDES - 1 - s;

        ptx_side_latch #(.DATA_W(DATA_W)) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .le       (le_v[s]),
            .pin_word (pin_w[s]),
            .drv_word (drv_w[s]),
            .drv_en   (drv_en[s]),
            .src_word (src_w[s]),
            .chk_word (chk_w[s])
        );

        ptx_route #(.DATA_W(DATA_W)) u_route (
            .src_word (src_w[PEER]),
            .fwd_mode (fwd_mode),
            .odd_sel  (odd_sel),
            .out_word (drv_w[s])
        );

        ptx_checker #(.DATA_W(DATA_W)) u_check (
            .chk_word (chk_w[s]),
            .odd_sel  (odd_sel),
            .err_n    (err_v[s])
        );
    end

    // Port outputs: zero when a side is not driven.
    always_comb begin
        a_oe     = drv_en[SIDE_A];
        b_oe     = drv_en[SIDE_B];
        a_data_o = drv_en[SIDE_A] ? drv_w[SIDE_A][DATA_W-1:0] : '0;
        a_par_o  = drv_en[SIDE_A] ? drv_w[SIDE_A][DATA_W]     : 1'b0;
        b_data_o = drv_en[SIDE_B] ? drv_w[SIDE_B][DATA_W-1:0] : '0;
        b_par_o  = drv_en[SIDE_B] ? drv_w[SIDE_B][DATA_W]     : 1'b0;
        a_err_n  = err_v[SIDE_A];
        b_err_n  = err_v[SIDE_B];
    end

    // Never drive both buses at once.
    assert_oe_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe));

    // Conflict resolves toward the A-to-B direction.
    assert_conflict_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dir_conflict |-> (b_oe && !a_oe));

    // Generated parity on side B obeys the selected sense.
    assert_gen_sense_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && !fwd_mode) |-> ((^{b_par_o, b_data_o}) == odd_sel));

    // Feed-through copies the source parity bit.
    assert_feed_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && fwd_mode) |-> (b_par_o == src_w[SIDE_A][DATA_W]));

    // Undriven side outputs stay at zero.
    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !a_oe |-> (a_data_o == '0 && !a_par_o));
endmodule

// File: tb/test_par_xcvr.sv
// Bench: exhaustive control sweep with injected parity and data errors.
module test_par_xcvr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       drv_ab_n = 1'b1, drv_ba_n = 1'b1, fwd_mode = 1'b0, odd_sel = 1'b0;
    logic       cap_a = 1'b0, cap_b = 1'b0;
    logic [7:0] a_data_i = '0, b_data_i = '0;
    logic       a_par_i = 1'b0, b_par_i = 1'b0;
    logic [7:0] a_data_o, b_data_o;
    logic       a_par_o, b_par_o, a_oe, b_oe, a_err_n, b_err_n, dir_conflict;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [8:0] held_a = '0, held_b = '0;
    logic [7:0] lfsr = 8'h1D;

    always #5 clk = ~clk;

    par_xcvr #(.DATA_W(8)) i_par_xcvr (
        .clk(clk), .rst_n(rst_n), .drv_ab_n(drv_ab_n), .drv_ba_n(drv_ba_n),
        .fwd_mode(fwd_mode), .odd_sel(odd_sel), .cap_a(cap_a), .cap_b(cap_b),
        .a_data_i(a_data_i), .a_par_i(a_par_i), .a_data_o(a_data_o),
        .a_par_o(a_par_o), .a_oe(a_oe), .b_data_i(b_data_i), .b_par_i(b_par_i),
        .b_data_o(b_data_o), .b_par_o(b_par_o), .b_oe(b_oe),
        .a_err_n(a_err_n), .b_err_n(b_err_n), .dir_conflict(dir_conflict)
    );

    function automatic logic ones_odd(input logic [8:0] w);
        int c = 0;
        for (int i = 0; i < 9; i++) c += int'(w[i]);
        return logic'(c % 2);
    endfunction

    function automatic logic gen_par(input logic [7:0] d, input logic odd);
        return ones_odd({1'b0, d}) ^ odd;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [5:0] ctl, input logic [2:0] pat);
        logic [7:0] ad, bd;
        logic ap, bp, e_aoe, e_boe;
        logic [8:0] src_a, src_b, to_a, to_b, live_a, live_b, chk_a, chk_b;
        @(posedge clk);
        #2;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        ad = lfsr;
        bd = lfsr ^ 8'hA5;
        ap = gen_par(ad, ctl[3]) ^ pat[0];
        bp = gen_par(bd, ctl[3]) ^ pat[1];
        if (pat[2]) begin
            ad = ad ^ (8'h01 << lfsr[2:0]);
            bd = bd ^ (8'h80 >> lfsr[5:3]);
        end
        drv_ab_n = ctl[0]; drv_ba_n = ctl[1]; fwd_mode = ctl[2]; odd_sel = ctl[3];
        cap_a = ctl[4]; cap_b = ctl[5];
        a_data_i = ad; a_par_i = ap; b_data_i = bd; b_par_i = bp;
        @(negedge clk);
        e_boe = !ctl[0];
        e_aoe = !ctl[1] && ctl[0];
        src_a = ctl[4] ? {ap, ad} : held_a;
        src_b = ctl[5] ? {bp, bd} : held_b;
        to_b = {(ctl[2] ? src_a[8] : gen_par(src_a[7:0], ctl[3])), src_a[7:0]};
        to_a = {(ctl[2] ? src_b[8] : gen_par(src_b[7:0], ctl[3])), src_b[7:0]};
        live_a = e_aoe ? to_a : {ap, ad};
        live_b = e_boe ? to_b : {bp, bd};
        chk_a = ctl[4] ? live_a : held_a;
        chk_b = ctl[5] ? live_b : held_b;
        check((!ctl[0] && !ctl[1]) ? "R3 conflict" : "R1 conflict", 32'(dir_conflict), 32'(!ctl[0] && !ctl[1]));
        check((ctl[0] && ctl[1]) ? "R1 b_oe" : "R2 b_oe", 32'(b_oe), 32'(e_boe));
        check((!ctl[0] && !ctl[1]) ? "R3 a_oe" : "R2 a_oe", 32'(a_oe), 32'(e_aoe));
        if (e_boe) begin
            check(ctl[4] ? "R4 b_data" : "R5 b_data", 32'(b_data_o), 32'(to_b[7:0]));
            check(ctl[2] ? "R7 b_par" : "R6 b_par", 32'(b_par_o), 32'(to_b[8]));
        end else begin
            check("R11 b idle", 32'({b_par_o, b_data_o}), 32'(0));
        end
        if (e_aoe) begin
            check(ctl[5] ? "R2 a_data" : "R5 a_data", 32'(a_data_o), 32'(to_a[7:0]));
            check(ctl[2] ? "R7 a_par" : "R6 a_par", 32'(a_par_o), 32'(to_a[8]));
        end else begin
            check("R11 a idle", 32'({a_par_o, a_data_o}), 32'(0));
        end
        check((e_aoe && ctl[4]) ? "R9 a_err" : "R8 a_err", 32'(a_err_n), 32'(ones_odd(chk_a) == ctl[3]));
        check((e_boe && ctl[5]) ? "R9 b_err" : "R8 b_err", 32'(b_err_n), 32'(ones_odd(chk_b) == ctl[3]));
        if (ctl[4]) held_a = live_a;
        if (ctl[5]) held_b = live_b;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        a_data_i = 8'hFF; a_par_i = 1'b1; b_data_i = 8'h3C; b_par_i = 1'b0;
        @(negedge clk);
        check("R1 a_oe idle", 32'(a_oe), 32'(0));
        check("R1 b_oe idle", 32'(b_oe), 32'(0));
        check("R10 a_err even", 32'(a_err_n), 32'(1));
        check("R10 b_err even", 32'(b_err_n), 32'(1));
        odd_sel = 1'b1;
        #1;
        check("R10 a_err odd", 32'(a_err_n), 32'(0));
        check("R10 b_err odd", 32'(b_err_n), 32'(0));
        drv_ab_n = 1'b0;
        #1;
        check("R10 held data", 32'(b_data_o), 32'(0));
        drv_ab_n = 1'b1; odd_sel = 1'b0;
        for (int c = 0; c < 64; c++) begin
            for (int p = 0; p < 8; p++) begin
                step(6'(c), 3'(p));
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule